// File: doc/BRIEF.md
# Maskable Control Register Bank with Retained Hidden Fields

This block is a two-register control bank on a simple register access port. A control register carries one enable bit, the half-word alignment enable. A context register carries three fields: the bit-1 position of a saved exception return address, a 2-bit operating mode with one reserved encoding, and an 8-bit tag. When the enable bit is clear, every context field is read-only and reads as zero. Its storage flops are kept, though, and they go on accepting writes.

The value shown to software and to downstream logic is always the masked, readable value. The raw flops only matter once the enable bit is set again. At that point the fields show whatever was last legally written, including writes made while they were masked. The mode field is legalized the same way whether it is masked or not: a write of the reserved code leaves the stored mode unchanged.

Reads are combinational from the current state. Writes take effect on the rising clock edge. A separate debug output exposes the raw hidden flops for verification and feeds no functional output.

Top module: `csr_mask_bank`

## Requirements
- R1: After reset the enable bit reads 1, and every context field, both stored and shown, is zero.
- R2: The control register sits at address 0x7C0. Bit 0 is the enable and is written from write-data bit 0. All other bits read zero.
- R3: The context register sits at address 0x7C1. Bit 1 is the return-address half bit, bits [5:4] are the mode and bits [15:8] are the tag. Bit 0 and every other bit always read zero. With the enable set, the stored fields are shown.
- R4: With the enable clear, a read of the context register returns zero.
- R5: A context write updates the stored fields in the same way whether or not they are masked.
- R6: A mode write of the reserved code 2'b10 leaves the stored mode unchanged, masked or not. The stored mode never holds 2'b10.
- R7: Changing the enable bit never changes the stored context fields, so unmasking reveals the values held before.
- R8: Reads of any other address return zero, and writes to other addresses change no state.
- R9: While a control write is presented, reads and effective outputs still follow the old enable. The new masking applies after the clock edge.
- R10: The effective outputs (enable, half bit, mode, tag) carry the masked values, which are zero while the enable is clear. The debug output carries the raw flops in the context-register bit positions.
- R11: With the write strobe low, no state changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, zero when the read strobe is low |
| eff_half_en | output | 1 | Effective half-word alignment enable |
| eff_epc_b1 | output | 1 | Effective return-address bit 1 |
| eff_mode | output | 2 | Effective mode |
| eff_tag | output | 8 | Effective tag |
| dbg_hidden | output | 32 | Raw context flops, for verification only |

## Verification
A write presented before a rising edge is visible on the read data, the effective outputs and the debug output in the first half-cycle after that edge. Read data also follows the address and strobe combinationally, with no added cycle. The bench therefore drives every input on the falling edge and samples results on the following falling edge, or a settle delay after changing only read inputs. The one case checked before an edge is the control write, which confirms that the old masking still holds while that write is pending.

// File: rtl/csr_mask_pkg.sv
package csr_mask_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned HALF_POS  = 1;
  localparam int unsigned MODE_LSB  = 4;
  localparam int unsigned MODE_W    = 2;
  localparam int unsigned TAG_LSB   = 8;
  localparam int unsigned TAG_W     = 8;
  localparam logic [MODE_W-1:0] MODE_RSVD = 2'b10;

  typedef struct packed {
    logic              half_b1;
    logic [MODE_W-1:0] mode;
    logic [TAG_W-1:0]  tag;
  } ctx_fields_t;

  function automatic logic [XLEN-1:0] pack_ctx(ctx_fields_t f);
    logic [XLEN-1:0] w;
    w = '0;
    w[HALF_POS]                    = f.half_b1;
    w[MODE_LSB +: MODE_W]          = f.mode;
    w[TAG_LSB +: TAG_W]            = f.tag;
    return w;
  endfunction
endpackage

// File: rtl/csr_enable_reg.sv
module csr_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic en_q
);
  logic en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b1;
    else if (wr_en) en_q <= en_d;
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q)); // R11
  AST_EN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q == $past(wr_bit)); // R2
endmodule

// File: rtl/csr_hidden_field.sv
module csr_hidden_field #(
  parameter int unsigned   W        = 1,
  parameter bit            HAS_RSVD = 1'b0,
  parameter logic [W-1:0]  RSVD_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         visible,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] eff
);
  logic         is_rsvd;
  logic         take;
  logic [W-1:0] raw_d;

  always_comb begin
    is_rsvd = HAS_RSVD && (wr_val == RSVD_VAL);
    take    = wr_en && !is_rsvd;
    raw_d   = take ? wr_val : raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    raw_q <= '0;
    else if (take) raw_q <= raw_d;
  end

  always_comb eff = visible ? raw_q : '0;

  AST_FIELD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(HAS_RSVD && wr_val == RSVD_VAL)) |=> raw_q == $past(wr_val)); // R5
  AST_FIELD_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && HAS_RSVD && wr_val == RSVD_VAL) |=> raw_q == $past(raw_q)); // R6
  AST_FIELD_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(raw_q)); // R7
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux #(
  parameter int unsigned        ADDR_W    = 12,
  parameter int unsigned        DATA_W    = 32,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR = 12'h7C0,
  parameter logic [ADDR_W-1:0]  CTX_ADDR  = 12'h7C1
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] ctx_word,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        CTRL_ADDR: rdata = ctrl_word;
        CTX_ADDR:  rdata = ctx_word;
        default:   rdata = '0;
      endcase
    end
  end

  always_comb begin
    if (rd && addr != CTRL_ADDR && addr != CTX_ADDR)
      AST_UNMAPPED_ZERO: assert (rdata == '0); // R8
  end
endmodule

// File: rtl/csr_mask_bank.sv
module csr_mask_bank #(
  parameter int unsigned       ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h7C0,
  parameter logic [ADDR_W-1:0] CTX_ADDR  = 12'h7C1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            csr_addr,
  input  logic                         csr_rd,
  input  logic                         csr_wr,
  input  logic [csr_mask_pkg::XLEN-1:0] csr_wdata,
  output logic [csr_mask_pkg::XLEN-1:0] csr_rdata,
  output logic                         eff_half_en,
  output logic                         eff_epc_b1,
  output logic [csr_mask_pkg::MODE_W-1:0] eff_mode,
  output logic [csr_mask_pkg::TAG_W-1:0]  eff_tag,
  output logic [csr_mask_pkg::XLEN-1:0] dbg_hidden
);
  import csr_mask_pkg::*;

  logic              wr_ctrl, wr_ctx;
  logic              en_q;
  ctx_fields_t       raw_f, eff_f;
  logic [XLEN-1:0]   ctrl_word, ctx_word;

  always_comb begin
    wr_ctrl = csr_wr && (csr_addr == CTRL_ADDR);
    wr_ctx  = csr_wr && (csr_addr == CTX_ADDR);
  end

  csr_enable_reg u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ctrl),
    .wr_bit (csr_wdata[0]),
    .en_q   (en_q)
  );

  csr_hidden_field #(.W(1)) u_half (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ctx),
    .wr_val  (csr_wdata[HALF_POS]),
    .visible (en_q),
    .raw_q   (raw_f.half_b1),
    .eff     (eff_f.half_b1)
  );

  csr_hidden_field #(.W(MODE_W), .HAS_RSVD(1'b1), .RSVD_VAL(MODE_RSVD)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ctx),
    .wr_val  (csr_wdata[MODE_LSB +: MODE_W]),
    .visible (en_q),
    .raw_q   (raw_f.mode),
    .eff     (eff_f.mode)
  );

  csr_hidden_field #(.W(TAG_W)) u_tag (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ctx),
    .wr_val  (csr_wdata[TAG_LSB +: TAG_W]),
    .visible (en_q),
    .raw_q   (raw_f.tag),
    .eff     (eff_f.tag)
  );

  always_comb begin
    ctrl_word    = '0;
    ctrl_word[0] = en_q;
    ctx_word     = pack_ctx(eff_f);
    dbg_hidden   = pack_ctx(raw_f);
    eff_half_en  = en_q;
    eff_epc_b1   = eff_f.half_b1;
    eff_mode     = eff_f.mode;
    eff_tag      = eff_f.tag;
  end

  csr_read_mux #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (XLEN),
    .CTRL_ADDR (CTRL_ADDR),
    .CTX_ADDR  (CTX_ADDR)
  ) u_rmux (
    .rd        (csr_rd),
    .addr      (csr_addr),
    .ctrl_word (ctrl_word),
    .ctx_word  (ctx_word),
    .rdata     (csr_rdata)
  );

  AST_MASKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_addr == CTX_ADDR && !en_q) |-> csr_rdata == '0); // R4
  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_addr == CTX_ADDR) |-> csr_rdata[0] == 1'b0); // R3
  AST_MODE_NEVER_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_hidden[MODE_LSB +: MODE_W] != MODE_RSVD); // R6
  AST_EFF_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_half_en |-> (eff_epc_b1 == 1'b0 && eff_mode == '0 && eff_tag == '0)); // R10
  AST_TOGGLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wr_ctx) |=> $stable(dbg_hidden)); // R7
endmodule

// File: tb/csr_mask_bank_test.sv
module csr_mask_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h7C0;
  localparam logic [11:0] A_CTX  = 12'h7C1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] csr_addr;
  logic        csr_rd, csr_wr;
  logic [31:0] csr_wdata, csr_rdata, dbg_hidden;
  logic        eff_half_en, eff_epc_b1;
  logic [1:0]  eff_mode;
  logic [7:0]  eff_tag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic       m_en;
  logic       m_b1;
  logic [1:0] m_mode;
  logic [7:0] m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_mask_bank uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .eff_half_en(eff_half_en), .eff_epc_b1(eff_epc_b1), .eff_mode(eff_mode),
    .eff_tag(eff_tag), .dbg_hidden(dbg_hidden)
  );

  function automatic logic [31:0] raw_word();
    return {16'h0, m_tag, 2'b00, m_mode, 2'b00, m_b1, 1'b0};
  endfunction

  function automatic logic [31:0] shown_word();
    return m_en ? raw_word() : 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1; csr_rd = 1'b0;
    @(negedge clk);
    csr_wr = 1'b0;
    if (a == A_CTRL) m_en = d[0];
    if (a == A_CTX) begin
      m_b1 = d[1];
      if (d[5:4] != 2'b10) m_mode = d[5:4];
      m_tag = d[15:8];
    end
  endtask

  task automatic read_chk(string req, logic [11:0] a, logic [31:0] exp);
    csr_addr = a; csr_rd = 1'b1;
    #1;
    chk(req, csr_rdata, exp);
    csr_rd = 1'b0;
    #1;
  endtask

  task automatic eff_chk(string req);
    chk(req, {20'h0, eff_half_en, eff_epc_b1, eff_mode, eff_tag},
        {20'h0, m_en, m_en & m_b1, m_en ? m_mode : 2'b00, m_en ? m_tag : 8'h00});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_addr = '0; csr_rd = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
    m_en = 1'b1; m_b1 = 1'b0; m_mode = 2'b00; m_tag = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_chk("R1 ctrl reset", A_CTRL, 32'h1);
    read_chk("R1 ctx reset", A_CTX, 32'h0);
    chk("R1 hidden reset", dbg_hidden, 32'h0);
    eff_chk("R1 eff reset");

    // R2/R3/R4/R5/R6/R10 sweep under both enable values
    for (int e = 0; e < 2; e++) begin
      do_write(A_CTRL, 32'hFFFF_FFFE | 32'(e));
      read_chk("R2 ctrl readback", A_CTRL, 32'(e));
      for (int i = 0; i < 256; i++) begin
        logic [7:0] b;
        b = 8'(i);
        do_write(A_CTX, {16'hC3C3, b ^ 8'h3C, 2'b10, b[1:0], 2'b01, b[2], 1'b1});
        read_chk(e ? "R3 ctx visible" : "R4 ctx masked", A_CTX, shown_word());
        chk("R5/R6 hidden flops", dbg_hidden, raw_word());
        eff_chk("R10 effective outputs");
      end
    end

    // R7 stored values survive enable toggles in both directions
    do_write(A_CTRL, 32'h0);
    do_write(A_CTX, 32'h0000_A532);
    do_write(A_CTRL, 32'h1);
    read_chk("R7 unmask reveals masked write", A_CTX, 32'h0000_A532 & 32'h0000_FF32);
    do_write(A_CTX, 32'h0000_5A12);
    do_write(A_CTRL, 32'h0);
    chk("R7 mask keeps flops", dbg_hidden, 32'h0000_5A12);
    do_write(A_CTX, 32'h0000_FF20); // reserved mode while masked
    do_write(A_CTRL, 32'h1);
    read_chk("R6 masked reserved keeps mode", A_CTX, 32'h0000_FF10);

    // R9 pending control write does not change masking before the edge
    @(negedge clk);
    csr_addr = A_CTRL; csr_wdata = 32'h0; csr_wr = 1'b1; csr_rd = 1'b1;
    #1;
    chk("R9 old enable before edge", {31'h0, eff_half_en}, 32'h1);
    chk("R9 old ctrl read before edge", csr_rdata, 32'h1);
    eff_chk("R9 eff before edge");
    @(negedge clk);
    csr_wr = 1'b0; m_en = 1'b0;
    eff_chk("R9 eff after edge");
    chk("R9 ctrl read after edge", csr_rdata, 32'h0);
    csr_rd = 1'b0;
    do_write(A_CTRL, 32'h1);

    // R11 no strobe no change
    @(negedge clk);
    csr_addr = A_CTX; csr_wdata = 32'h0000_0000; csr_rd = 1'b1;
    @(negedge clk);
    csr_addr = A_CTRL;
    @(negedge clk);
    csr_rd = 1'b0;
    chk("R11 idle keeps ctx", dbg_hidden, raw_word());
    read_chk("R11 idle keeps ctrl", A_CTRL, 32'h1);

    // R8 unmapped addresses: reads zero, writes ignored
    for (int a = 0; a < 4096; a++) begin
      if (12'(a) != A_CTRL && 12'(a) != A_CTX)
        read_chk("R8 unmapped read", 12'(a), 32'h0);
    end
    for (int a = 0; a < 4096; a += 7) begin
      if (12'(a) != A_CTRL && 12'(a) != A_CTX)
        do_write(12'(a), 32'h0000_0000);
    end
    read_chk("R8 ctx after unmapped writes", A_CTX, shown_word());
    read_chk("R8 ctrl after unmapped writes", A_CTRL, 32'h1);
    chk("R8 flops after unmapped writes", dbg_hidden, raw_word());

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule